// File: doc/BRIEF.md
# Half-Cycle Synchronized Energy Integrator

The block sums a stream of signed power samples over a programmed number of half-line cycles. Window edges fall only on a single-cycle strobe that marks each voltage zero crossing, so every window holds an integral number of half cycles. When a window completes, the top bits of the wide running sum are captured into a 24-bit result register. A sticky completion flag is raised, and an interrupt is requested when it is enabled.

Operation is continuous. The crossing that closes one window also opens the next, with no lost sample between them. A result that nobody reads is replaced by the next one. Software programs the half-cycle count through a write strobe. Each such write throws away the partial sum and disarms the block, and counting resumes at the next crossing. The first completion after a write is therefore always a full window. A count of zero keeps the block idle.

Top module: `lcyc_energy_acc`

## Requirements
- R1: After reset the result is 0, the flag and interrupt are low, and the half-cycle count is 0.
- R2: While the programmed count is 0, crossings never arm the block and the flag never rises.
- R3: The first crossing after a count write arms the block and opens a window. The window spans the arming cycle up to, but not including, the cycle of the N-th following crossing. At the edge that samples that crossing, the result takes bits [39:16] of the 40-bit two's-complement sum of the window's samples, which is the floor of sum/65536 kept to 24 bits. The flag rises at the same edge.
- R4: Samples with `pwr_vld` low add nothing. Samples taken after a count write and before the arming crossing add nothing.
- R5: The closing crossing opens the next window at once, and the sample in that cycle belongs to the new window. The next completion overwrites the result whether or not it was read.
- R6: A count write discards the partial sum and disarms the block. A write in the same cycle as a crossing takes priority, so that crossing neither arms nor counts.
- R7: `irq` is high exactly when the flag is set and `irq_en` is high.
- R8: A cycle with `flag_clr` high clears the flag (write one to clear). A completion in the same cycle keeps the flag set. With `flag_clr` low the flag holds.
- R9: The result changes only at a window completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_vld | input | 1 | Sample valid |
| pwr_smp | input | 16 | Signed power sample |
| zc_stb | input | 1 | One-cycle zero-crossing strobe |
| hc_wr | input | 1 | Half-cycle count write strobe |
| hc_wdata | input | 16 | Half-cycle count write data |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear for the completion flag |
| energy_q | output | 24 | Latched window energy |
| cyc_flag | output | 1 | Sticky window-completion flag |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same cycle. A window completion can coincide with a flag clear, and a count write can coincide with a zero crossing. The bench drives the clear strobe on the exact cycle of the closing crossing and expects the flag to stay set. It also issues a count write together with a crossing and then counts out one full window from the next crossing. A result that matches only that full window shows the coincident crossing was ignored.

// File: rtl/lcyc_pkg.sv
package lcyc_pkg;

  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_RUN  = 1'b1
  } win_state_t;

  // Upper-bit extraction of the running sum (logical shift, caller truncates).
  function automatic logic [63:0] take_top(input logic [63:0] acc, input int unsigned shift);
    return acc >> shift;
  endfunction

  // Next half-cycle index and whether it closes the window.
  function automatic logic closes_window(input logic [31:0] idx, input logic [31:0] limit);
    return (idx + 32'd1) == limit;
  endfunction

endpackage

// File: rtl/lcyc_window_ctl.sv
module lcyc_window_ctl
  import lcyc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zc_stb,
  input  logic             hc_wr,
  input  logic [CNT_W-1:0] hc_wdata,
  output logic             armed,
  output logic             win_start,
  output logic             win_end
);

  win_state_t       state_q;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] hidx_q;
  logic             enabled;
  logic             run_zc;

  assign enabled   = (limit_q != '0);
  assign armed     = (state_q == WIN_RUN);
  assign run_zc    = armed && zc_stb && !hc_wr;
  assign win_start = (state_q == WIN_IDLE) && zc_stb && !hc_wr && enabled;
  assign win_end   = run_zc && closes_window(32'(hidx_q), 32'(limit_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WIN_IDLE;
      limit_q <= '0;
      hidx_q  <= '0;
    end else if (hc_wr) begin
      limit_q <= hc_wdata;
      state_q <= WIN_IDLE;
      hidx_q  <= '0;
    end else if (win_start) begin
      state_q <= WIN_RUN;
      hidx_q  <= '0;
    end else if (run_zc) begin
      hidx_q  <= win_end ? '0 : hidx_q + 1'b1;
    end
  end

  assert_idx_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (hidx_q < limit_q));
  assert_zero_count_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_q == '0) |-> !win_end && !win_start);
  assert_rewrite_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hc_wr |=> !armed);
  assert_end_needs_crossing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |-> zc_stb && $past(armed || win_start || !hc_wr));

endmodule

// File: rtl/lcyc_integrator.sv
module lcyc_integrator #(
  parameter int PWR_W = 16,
  parameter int ACC_W = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    armed,
  input  logic                    win_start,
  input  logic                    win_end,
  input  logic                    discard,
  input  logic                    pwr_vld,
  input  logic signed [PWR_W-1:0] pwr_smp,
  output logic        [ACC_W-1:0] acc_q
);

  function automatic logic [ACC_W-1:0] widen(input logic signed [PWR_W-1:0] s);
    return ACC_W'(s);
  endfunction

  logic [ACC_W-1:0] addend;
  logic             restart;

  assign addend  = pwr_vld ? widen(pwr_smp) : '0;
  assign restart = win_start || win_end;

  always_ff @(posedge clk) begin
    if (!rst_n || discard) begin
      acc_q <= '0;
    end else if (restart) begin
      acc_q <= addend;
    end else if (armed) begin
      acc_q <= acc_q + addend;
    end
  end

  assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !win_start && !discard) |=> $stable(acc_q));
  assert_discard_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> (acc_q == '0));

endmodule

// File: rtl/lcyc_status.sv
module lcyc_status
  import lcyc_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int OUT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_end,
  input  logic [ACC_W-1:0] acc_q,
  input  logic             flag_clr,
  input  logic             irq_en,
  output logic [OUT_W-1:0] energy_q,
  output logic             cyc_flag,
  output logic             irq
);

  localparam int unsigned SHIFT = ACC_W - OUT_W;

  logic [OUT_W-1:0] energy_d;

  assign energy_d = OUT_W'(take_top(64'(acc_q), SHIFT));
  assign irq      = cyc_flag && irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      energy_q <= '0;
      cyc_flag <= 1'b0;
    end else begin
      if (win_end) energy_q <= energy_d;
      if (win_end)       cyc_flag <= 1'b1;
      else if (flag_clr) cyc_flag <= 1'b0;
    end
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> cyc_flag);
  assert_flag_falls_on_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cyc_flag) |-> $past(flag_clr));
  assert_energy_moves_on_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(energy_q) |-> $past(win_end));
  assert_no_irq_without_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_flag |-> !irq);

endmodule

// File: rtl/lcyc_energy_acc.sv
module lcyc_energy_acc #(
  parameter int PWR_W = 16,
  parameter int ACC_W = 40,
  parameter int OUT_W = 24,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pwr_vld,
  input  logic signed [PWR_W-1:0] pwr_smp,
  input  logic                    zc_stb,
  input  logic                    hc_wr,
  input  logic        [CNT_W-1:0] hc_wdata,
  input  logic                    irq_en,
  input  logic                    flag_clr,
  output logic        [OUT_W-1:0] energy_q,
  output logic                    cyc_flag,
  output logic                    irq
);

  logic             armed;
  logic             win_start;
  logic             win_end;
  logic [ACC_W-1:0] acc_q;

  lcyc_window_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .zc_stb   (zc_stb),
    .hc_wr    (hc_wr),
    .hc_wdata (hc_wdata),
    .armed    (armed),
    .win_start(win_start),
    .win_end  (win_end)
  );

  lcyc_integrator #(.PWR_W(PWR_W), .ACC_W(ACC_W)) u_int (
    .clk      (clk),
    .rst_n    (rst_n),
    .armed    (armed),
    .win_start(win_start),
    .win_end  (win_end),
    .discard  (hc_wr),
    .pwr_vld  (pwr_vld),
    .pwr_smp  (pwr_smp),
    .acc_q    (acc_q)
  );

  lcyc_status #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_end  (win_end),
    .acc_q    (acc_q),
    .flag_clr (flag_clr),
    .irq_en   (irq_en),
    .energy_q (energy_q),
    .cyc_flag (cyc_flag),
    .irq      (irq)
  );

  assert_start_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_start && win_end));

endmodule

// File: tb/lcyc_energy_acc_test.sv
module lcyc_energy_acc_test;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               pwr_vld = 1'b0;
  logic signed [15:0] pwr_smp = '0;
  logic               zc_stb = 1'b0;
  logic               hc_wr = 1'b0;
  logic [15:0]        hc_wdata = '0;
  logic               irq_en = 1'b0;
  logic               flag_clr = 1'b0;
  logic [23:0]        energy_q;
  logic               cyc_flag;
  logic               irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lcyc_energy_acc uut (.*);

  typedef struct packed {
    logic [15:0] n;
    logic [7:0]  gap;
    logic [15:0] smp;
    logic        sparse;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{n: 16'd1, gap: 8'd10, smp: 16'd20000,  sparse: 1'b0},
    '{n: 16'd3, gap: 8'd20, smp: 16'd30000,  sparse: 1'b0},
    '{n: 16'd2, gap: 8'd16, smp: -16'sd30000, sparse: 1'b0},
    '{n: 16'd5, gap: 8'd12, smp: 16'd32767,  sparse: 1'b1}
  };

  function automatic logic [23:0] expect_energy(input int n, input int gap, input int s, input bit sparse);
    longint per, total;
    per   = sparse ? longint'((gap + 1) / 2) : longint'(gap);
    total = longint'(n) * per * longint'(s);
    return 24'(total >>> 16);
  endfunction

  task automatic check(input string req, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step(input logic z, input logic v, input logic signed [15:0] s,
                      input logic w, input logic [15:0] wd, input logic c);
    zc_stb = z; pwr_vld = v; pwr_smp = s; hc_wr = w; hc_wdata = wd; flag_clr = c;
    @(posedge clk);
    #1;
    zc_stb = 1'b0; hc_wr = 1'b0; flag_clr = 1'b0; pwr_vld = 1'b0;
  endtask

  // One half cycle: crossing in the first cycle; optional check right after it.
  task automatic half(input int gap, input logic signed [15:0] s, input bit sparse,
                      input bit chk, input logic [23:0] exp, input string req);
    for (int i = 0; i < gap; i++) begin
      step(i == 0, sparse ? (i % 2 == 0) : 1'b1, s, 1'b0, 16'd0, 1'b0);
      if (i == 0 && chk) begin
        check({req, " flag"}, cyc_flag, 1);
        check({req, " energy"}, energy_q, exp);
      end
    end
  endtask

  task automatic write_cnt(input logic [15:0] n);
    step(1'b0, 1'b0, 16'sd0, 1'b1, n, 1'b0);
  endtask

  task automatic clear_flag();
    step(1'b0, 1'b0, 16'sd0, 1'b0, 16'd0, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [23:0] e1, e2;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    check("R1 energy", energy_q, 0);
    check("R1 flag", cyc_flag, 0);
    check("R1 irq", irq, 0);
    // R1/R2: count is 0 after reset, crossings do nothing
    for (int h = 0; h < 4; h++) half(6, 16'sd5000, 1'b0, 1'b0, 24'd0, "R2");
    check("R2 idle after reset", cyc_flag, 0);

    // Table: R3 window value, R4 pre-arm and sparse samples, R5 back-to-back overwrite
    foreach (VECS[k]) begin
      e1 = expect_energy(int'(VECS[k].n), int'(VECS[k].gap), int'($signed(VECS[k].smp)), VECS[k].sparse);
      e2 = expect_energy(int'(VECS[k].n), int'(VECS[k].gap), -int'($signed(VECS[k].smp)), VECS[k].sparse);
      clear_flag();
      write_cnt(VECS[k].n);
      for (int j = 0; j < 3; j++) step(1'b0, 1'b1, 16'sd31000, 1'b0, 16'd0, 1'b0); // R4 pre-arm
      for (int h = 0; h < int'(VECS[k].n); h++)
        half(int'(VECS[k].gap), $signed(VECS[k].smp), VECS[k].sparse, 1'b0, 24'd0, "R3");
      for (int h = 0; h < int'(VECS[k].n); h++)
        half(int'(VECS[k].gap), -$signed(VECS[k].smp), VECS[k].sparse, h == 0, e1, "R3/R4");
      step(1'b1, 1'b0, 16'sd0, 1'b0, 16'd0, 1'b0);
      check("R5 overwrite", energy_q, e2);
    end

    // R8: clear with flag low holds; clear coinciding with completion keeps flag set
    write_cnt(16'd1);
    clear_flag();
    check("R8 clear", cyc_flag, 0);
    half(8, 16'sd10000, 1'b0, 1'b0, 24'd0, "R8");
    step(1'b1, 1'b1, 16'sd0, 1'b0, 16'd0, 1'b1);
    check("R8 set wins", cyc_flag, 1);
    step(1'b0, 1'b0, 16'sd0, 1'b0, 16'd0, 1'b0);
    check("R8 holds without clear", cyc_flag, 1);
    clear_flag();
    check("R8 w1c", cyc_flag, 0);

    // R7: interrupt follows flag and enable
    irq_en = 1'b1;
    #1 check("R7 no flag no irq", irq, 0);
    write_cnt(16'd1);
    half(8, 16'sd10000, 1'b0, 1'b0, 24'd0, "R7");
    step(1'b1, 1'b0, 16'sd0, 1'b0, 16'd0, 1'b0);
    check("R7 irq set", irq, 1);
    irq_en = 1'b0;
    #1 check("R7 irq masked", irq, 0);
    irq_en = 1'b1;
    #1 check("R7 irq unmasked", irq, 1);
    clear_flag();
    check("R7 irq drops on clear", irq, 0);
    irq_en = 1'b0;

    // R6: rewrite mid-window discards partial sum
    write_cnt(16'd2);
    half(10, 16'sd30000, 1'b0, 1'b0, 24'd0, "R6");
    write_cnt(16'd1);
    half(10, -16'sd1000, 1'b0, 1'b0, 24'd0, "R6");
    step(1'b1, 1'b0, 16'sd0, 1'b0, 16'd0, 1'b0);
    check("R6 rewrite flag", cyc_flag, 1);
    check("R6 rewrite energy", energy_q, 24'hFFFFFF);
    clear_flag();

    // R6: write coinciding with a crossing; that crossing must not arm
    step(1'b1, 1'b1, 16'sd30000, 1'b1, 16'd1, 1'b0);
    half(10, 16'sd7000, 1'b0, 1'b0, 24'd0, "R6");
    check("R6 coincident no early end", cyc_flag, 0);
    step(1'b1, 1'b0, 16'sd0, 1'b0, 16'd0, 1'b0);
    check("R6 coincident energy", energy_q, expect_energy(1, 10, 7000, 1'b0));
    clear_flag();

    // R2: programmed zero disables
    write_cnt(16'd0);
    for (int h = 0; h < 5; h++) half(6, 16'sd20000, 1'b0, 1'b0, 24'd0, "R2");
    check("R2 zero count flag", cyc_flag, 0);
    check("R9 energy unchanged", energy_q, expect_energy(1, 10, 7000, 1'b0));

    finish_run();
  end

endmodule